// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus, in the style of I2C, sitting in front of a 2048-byte register memory. The bus master opens a transfer with a start condition. It sends an address byte and, for writes, an 8-bit word address, and then either streams data bytes in or clocks them out. The block drives SDA only through an open-drain pull-low enable. It detects start and stop conditions, acknowledges the bytes it accepts, and keeps an 11-bit address counter.

The address byte carries a 4-bit type code that must match, a 3-bit bank number and a read/write flag. The bank number forms the top of the memory address, so it is not used to pick one of several chips on the bus. Written bytes first go into a one-page staging buffer. A stop condition then starts a self-timed commit period that lasts a parameterised number of clock cycles. Until that period ends, the block ignores the bus completely and acknowledges nothing.

The states are ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK and ST_BUSY. Except in ST_BUSY, a start condition moves the block to ST_DEV, and a stop condition moves it to ST_BUSY if write data is staged, or to ST_IDLE if not. The other transitions happen on the falling edge of SCL:

- ST_DEV goes to ST_DEV_ACK after eight bits if the type code matches, and to ST_IDLE if it does not.
- ST_DEV_ACK goes to ST_RDATA for a read and to ST_WADDR for a write.
- ST_WADDR goes to ST_WADDR_ACK, and then to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK, and then back to ST_WDATA.
- ST_RDATA goes to ST_RACK after eight bits.
- ST_RACK goes to ST_RDATA if the master acknowledged, and to ST_IDLE if it did not.
- ST_BUSY goes to ST_IDLE when the commit timer expires.

Top module: `eep2w_slave`

## Requirements
- R1: The memory holds 2048 bytes, each 0xFF after reset. A location's 11-bit address is {bank[2:0], word[7:0]}.
- R2: The first byte after a start is acknowledged only when bits 7:4 equal 4'b1010. On a mismatch, SDA stays released until the next start.
- R3: Bits 3:1 of the address byte are the bank, which gives the upper three address bits for both writes and reads.
- R4: Bit 0 of the address byte selects the direction: 0 writes and 1 reads.
- R5: The block acknowledges by pulling SDA low for the whole ninth SCL clock. It does this after a matching address byte, after the word address, and after every write data byte.
- R6: A stop condition after at least one write data byte commits the staged bytes to memory.
- R7: After that stop, the block stays busy for exactly WR_CYCLES clock cycles. While busy it acknowledges nothing, keeps SDA released, and bytes sent to it have no effect.
- R8: One transfer can write up to 16 bytes. Within a page, the low 4 address bits step and wrap while bits 10:4 stay fixed, and all the bytes are committed in one busy period.
- R9: A start or stop condition is recognised only when SDA changes while SCL is high. The block changes its SDA drive only while SCL is low.
- R10: A read shifts out, MSB first, the byte at the address counter, and then increments the counter, wrapping at 11 bits. The block sends the next byte if the master acknowledges, and releases SDA if it does not.
- R11: A start that arrives before a stop discards any staged write data. A stop with nothing staged returns the block to idle with no busy period.
- R12: After reset, SDA is released and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples SCL and SDA |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND level) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest behaviour to reach is the busy window. Bus traffic has to land inside the commit period and then be shown to have had no effect. To do this, the bench issues a new start and address byte immediately after a write's stop and checks for the missing acknowledge. It then sends a full write that should be ignored, waits for the timer to expire, and reads the location back. Page-offset wrap and 11-bit read wrap come from writes that start two bytes before a page end and reads that start near the top address. The bench sweeps all sixteen type codes and all eight banks.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } eep_state_e;
endpackage

// File: rtl/eep2w_busfront.sv
// Synchronises SCL/SDA and flags clock edges plus start/stop conditions.
module eep2w_busfront #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic sda_o
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_d, sda_d, scl_s, sda_s;

    // Idle bus level is high; reset to it so release of reset never looks like a start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s      = scl_sync[SYNC_STAGES-1];
    assign sda_s      = sda_sync[SYNC_STAGES-1];
    assign scl_rise_o = scl_s & ~scl_d;
    assign scl_fall_o = ~scl_s & scl_d;
    assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
    assign sda_o      = sda_s;
endmodule

// File: rtl/eep2w_wtimer.sv
// Self-timed commit window: runs for exactly CYCLES clocks after a start pulse.
module eep2w_wtimer #(
    parameter int CYCLES = 250000,
    localparam int CNT_W = $clog2(CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) run_q <= 1'b0;
            else               cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy_o = run_q;
    assign done_o = run_q && (cnt_q == LAST);
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/eep2w_store.sv
// Byte array plus one-page staging buffer committed entry by entry.
module eep2w_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W,
    localparam int BASE_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              stage_we_i,
    input  logic [ADDR_W-1:0] stage_addr_i,
    input  logic [7:0]        stage_data_i,
    input  logic              commit_en_i,
    input  logic [PAGE_W-1:0] commit_idx_i,
    output logic              pending_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    logic [7:0]        mem_q [DEPTH];
    logic [7:0]        buf_q [PAGE_N];
    logic [PAGE_N-1:0] valid_q;
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            base_q  <= '0;
            for (int i = 0; i < PAGE_N; i++) buf_q[i] <= 8'h00;
        end else if (clr_i) begin
            valid_q <= '0;
        end else if (stage_we_i) begin
            buf_q[stage_addr_i[PAGE_W-1:0]]   <= stage_data_i;
            valid_q[stage_addr_i[PAGE_W-1:0]] <= 1'b1;
            base_q <= stage_addr_i[ADDR_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit_en_i && valid_q[commit_idx_i]) begin
            mem_q[{base_q, commit_idx_i}] <= buf_q[commit_idx_i];
        end
    end

    assign pending_o = |valid_q;
    assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
    import eep2w_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE  = 4'b1010,
    parameter int         ADDR_W    = 11,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_drive_low_o
);
    localparam int HI_W   = ADDR_W - 8;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(WR_CYCLES);

    eep_state_e state_q, state_d;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s;
    logic [7:0]        shreg_q;
    logic [3:0]        bit_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   hi_q;
    logic              rw_q, mack_q;
    logic              full, match, pending, go_busy, live;
    logic              t_busy, t_done;
    logic [CNT_W-1:0]  t_cnt;
    logic              stage_we, store_clr, commit_en;
    logic [7:0]        rd_data;

    eep2w_busfront u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det),
        .sda_o      (sda_s)
    );

    eep2w_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (go_busy),
        .busy_o  (t_busy),
        .done_o  (t_done),
        .cnt_o   (t_cnt)
    );

    eep2w_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (store_clr),
        .stage_we_i   (stage_we),
        .stage_addr_i (addr_q),
        .stage_data_i (shreg_q),
        .commit_en_i  (commit_en),
        .commit_idx_i (t_cnt[PAGE_W-1:0]),
        .pending_o    (pending),
        .rd_addr_i    (addr_q),
        .rd_data_o    (rd_data)
    );

    assign live      = (state_q != ST_BUSY);
    assign full      = (bit_cnt_q == 4'd8);
    assign match     = (shreg_q[7:4] == DEV_TYPE);
    assign go_busy   = live && !start_det && stop_det && pending;
    assign store_clr = (live && start_det) || t_done;
    assign stage_we  = live && !start_det && !stop_det && scl_fall && full
                       && (state_q == ST_WDATA);
    assign commit_en = t_busy && (t_cnt < CNT_W'(PAGE_N));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!live) begin
            if (t_done) state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = pending ? ST_BUSY : ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (full) state_d = match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   state_d = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (full) state_d = ST_WADDR_ACK;
                ST_WADDR_ACK: state_d = ST_WDATA;
                ST_WDATA:     if (full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_RDATA:     if (full) state_d = ST_RACK;
                ST_RACK:      state_d = mack_q ? ST_RDATA : ST_IDLE;
                ST_BUSY:      state_d = ST_BUSY;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath registers: shifter, bit counter, address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= 8'h00;
            bit_cnt_q <= 4'd0;
            addr_q    <= '0;
            hi_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
        end else if (live) begin
            if (start_det) begin
                bit_cnt_q <= 4'd0;
            end else if (scl_rise) begin
                if (state_q == ST_DEV || state_q == ST_WADDR || state_q == ST_WDATA)
                    shreg_q <= {shreg_q[6:0], sda_s};
                if (state_q == ST_RACK) mack_q <= ~sda_s;
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall) begin
                unique case (state_q)
                    ST_DEV: if (full) begin
                        bit_cnt_q <= 4'd0;
                        rw_q      <= shreg_q[0];
                        hi_q      <= shreg_q[HI_W:1];
                        if (shreg_q[0])
                            addr_q <= {shreg_q[HI_W:1], addr_q[ADDR_W-HI_W-1:0]};
                    end
                    ST_WADDR: if (full) begin
                        bit_cnt_q <= 4'd0;
                        addr_q    <= {hi_q, shreg_q};
                    end
                    ST_WDATA: if (full) begin
                        bit_cnt_q <= 4'd0;
                        addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                    end
                    ST_DEV_ACK, ST_RACK: begin
                        bit_cnt_q <= 4'd0;
                        if ((state_q == ST_DEV_ACK && rw_q) || (state_q == ST_RACK && mack_q)) begin
                            shreg_q <= rd_data;
                            addr_q  <= addr_q + ADDR_W'(1);
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: bit_cnt_q <= 4'd0;
                    ST_RDATA: if (!full) shreg_q <= {shreg_q[6:0], 1'b1};
                    default: ;
                endcase
            end
        end
    end

    // Output logic
    always_comb begin
        sda_drive_low_o = 1'b0;
        unique case (state_q)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_drive_low_o = 1'b1;
            ST_RDATA: sda_drive_low_o = ~shreg_q[7];
            default:  sda_drive_low_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/eep2w_slave_chk.sv
module eep2w_slave_chk
    import eep2w_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE  = 4'b1010,
    parameter int         ADDR_W    = 11,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive_low_o,
    input eep_state_e        state_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [7:0]        shreg_q
);
    localparam int BC_W = $clog2(WR_CYCLES + 2) + 1;
    logic [BC_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  busy_cnt <= '0;
        else if (state_q == ST_BUSY) busy_cnt <= busy_cnt + BC_W'(1);
        else                         busy_cnt <= '0;
    end

    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q == ST_BUSY) |-> busy_cnt == BC_W'(WR_CYCLES));

    a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_BUSY) |-> scl_i);

    a_r9_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !scl_i);

    a_r2_ack_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK && $past(state_q) == ST_DEV) |-> $past(shreg_q[7:4]) == DEV_TYPE);

    a_r8_page_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA_ACK && $past(state_q) == ST_WDATA)
        |-> $past(addr_q[ADDR_W-1:PAGE_W]) == addr_q[ADDR_W-1:PAGE_W]);
endmodule

bind eep2w_slave eep2w_slave_chk #(
    .DEV_TYPE(DEV_TYPE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_i),
    .sda_drive_low_o (sda_drive_low_o),
    .state_q         (state_q),
    .addr_q          (addr_q),
    .shreg_q         (shreg_q)
);

// File: tb/eep2w_slave_tb.sv
`timescale 1ns/1ps
module eep2w_slave_tb;
    localparam int WR = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low_o;
    logic sda_line;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] model [2048];
    logic [7:0] wbuf [16];

    always #10 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low_o;

    eep2w_slave #(.WR_CYCLES(WR)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl),
        .sda_i           (sda_line),
        .sda_drive_low_o (sda_drive_low_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(10); scl = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl = 1'b0; tick(10);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(10); scl = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(10); scl = 1'b1; tick(20); scl = 1'b0; tick(10);
        end
        sda_m = 1'b1; tick(10); scl = 1'b1; tick(10);
        ack = (sda_line == 1'b0);
        tick(10); scl = 1'b0; tick(10);
    endtask

    task automatic read_byte(output logic [7:0] b, input bit mack);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(10); scl = 1'b1; tick(10); b = {b[6:0], sda_line}; tick(10); scl = 1'b0;
        end
        tick(5); sda_m = mack ? 1'b0 : 1'b1; tick(5);
        scl = 1'b1; tick(20); scl = 1'b0; tick(10); sda_m = 1'b1;
    endtask

    function automatic logic [10:0] page_slot(input logic [10:0] a, input int i);
        return {a[10:4], 4'(a[3:0] + 4'(i))};
    endfunction

    // Write n bytes of wbuf from address a; model updated, busy period awaited.
    task automatic do_write(input logic [10:0] a, input int n);
        bit ack;
        bus_start;
        send_byte({4'b1010, a[10:8], 1'b0}, ack); chk(ack, "R5 dev ack", ack, 1);
        send_byte(a[7:0], ack);                   chk(ack, "R5 word ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); chk(ack, "R5 data ack", ack, 1);
            model[page_slot(a, i)] = wbuf[i];
        end
        bus_stop;
        if (n > 0) tick(WR + 100);
    endtask

    // Random read of n bytes starting at a, checked against the model.
    task automatic do_read(input logic [10:0] a, input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start;
        send_byte({4'b1010, a[10:8], 1'b0}, ack); chk(ack, "R4 write-dir ack", ack, 1);
        send_byte(a[7:0], ack);                   chk(ack, "R5 word ack", ack, 1);
        bus_start;
        send_byte({4'b1010, a[10:8], 1'b1}, ack); chk(ack, "R4 read-dir ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(d, i < n - 1);
            chk(d === model[11'(a + 11'(i))], req, d, model[11'(a + 11'(i))]);
        end
        bus_stop;
    endtask

    initial begin
        bit ack;
        logic [7:0] d;
        for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R12: reset state releases SDA
        chk(sda_drive_low_o == 1'b0, "R12 reset release", sda_drive_low_o, 0);

        // R2: sweep all 16 type codes, only 1010 acknowledged
        for (int t = 0; t < 16; t++) begin
            bus_start;
            send_byte({4'(t), 3'b000, 1'b0}, ack);
            chk(ack == (t == 10), "R2 type match", ack, t == 10);
            bus_stop;
        end

        // R1/R3/R6: one byte per bank at the same word address
        for (int b = 0; b < 8; b++) begin
            wbuf[0] = 8'(8'h15 + 8'(b * 37));
            do_write({3'(b), 8'h3C}, 1);
        end
        for (int b = 0; b < 8; b++) do_read({3'(b), 8'h3C}, 1, "R3 bank readback");
        do_read(11'h13D, 1, "R1 erased value");

        // R7: access during busy gets no ack and the write is ignored
        wbuf[0] = 8'h5C;
        bus_start;
        send_byte(8'b1010_010_0, ack); send_byte(8'hA5, ack); send_byte(wbuf[0], ack);
        bus_stop;
        model[11'h2A5] = 8'h5C;
        bus_start;
        send_byte(8'b1010_010_0, ack); chk(!ack, "R7 no ack while busy", ack, 0);
        send_byte(8'hA5, ack); send_byte(8'h00, ack);
        bus_stop;
        tick(WR + 200);
        do_read(11'h2A5, 1, "R7 busy write ignored");

        // R8: 16-byte page write starting at offset 14, wraps within page
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h31 + 8'(i * 7));
        do_write(11'h52E, 16);
        do_read(11'h520, 16, "R8 page contents");
        do_read(11'h530, 1, "R8 next page untouched");

        // R10: sequential read across the 11-bit wrap, then current-address read
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        do_write(11'h7FE, 2);
        wbuf[0] = 8'hB1; wbuf[1] = 8'hB2;
        do_write(11'h000, 2);
        do_read(11'h7FE, 4, "R10 sequential wrap");
        bus_start;
        send_byte(8'b1010_000_1, ack); chk(ack, "R10 current read ack", ack, 1);
        read_byte(d, 1'b0);
        chk(d === model[11'h002], "R10 counter increment", d, model[11'h002]);
        tick(20);
        chk(sda_line == 1'b1, "R10 release after nack", sda_line, 1);
        bus_stop;

        // R11: start before stop discards data; no busy period follows
        bus_start;
        send_byte(8'b1010_001_0, ack); send_byte(8'h44, ack); send_byte(8'h99, ack);
        bus_start;
        bus_stop;
        do_read(11'h144, 1, "R11 discarded write");

        // R9: SDA pulse while SCL low is not a start or stop
        bus_start;
        send_byte(8'b1010_000_0, ack);
        sda_m = 1'b0; tick(5); sda_m = 1'b1; tick(5);
        send_byte(8'h10, ack); chk(ack, "R9 word ack after glitch", ack, 1);
        send_byte(8'h3E, ack); chk(ack, "R9 data ack after glitch", ack, 1);
        bus_stop;
        model[11'h010] = 8'h3E;
        tick(WR + 100);
        do_read(11'h010, 1, "R9 write after glitch");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule